// File: doc/BRIEF.md
# Load Instruction Cycle Sequencer

This block is the control sequencer for the load-register instruction of a small 32-bit processor. It receives one start strobe with the decoded fields of a load and steps through three cycles. The first cycle forms the effective address. The second cycle puts the data read on the memory bus and may write back the base register. The third cycle writes the loaded value into the destination register. The memory bus has no work of its own in that third cycle, so the sequencer uses it for the next instruction's prefetch and issues one non-sequential fetch request there.

In the data cycle the block drives the transfer-size code and the translation-privilege flag. When the data read reports an abort, the destination write is suppressed. The base write-back is suppressed as well only when early-abort mode is configured. The block then raises a one-cycle abort-taken pulse and returns to idle. When a completed load writes the program counter, either as the destination or through base write-back, the block issues a one-cycle pipeline flush so that the prefetch stream restarts from the new address.

Top module: `loadSequencer`

## Requirements
- R1: After reset the block is idle: busy, addrPhase, memReq, baseWe, destWe, mergedFetch, flush and abortTaken are all 0.
- R2: A start sampled while idle gives the following sequence. In the next cycle only addrPhase is high among the phase outputs. In the cycle after that only memReq is high. In the third cycle destWe is high. Busy is high for all three cycles and is low again in the fourth.
- R3: During the data cycle xferSize equals sizeSel for 00 (byte), 01 (halfword) and 10 (word). A sizeSel of 11 is issued as 10. The code 11 never appears while memReq is high.
- R4: During the data cycle transPriv is 0 when userForm was set at start. Otherwise it equals the modePriv value sampled at start (0 means user mode, 1 means privileged).
- R5: baseWe is high only in the data cycle. It is high there when writeBack was set at start, unless abortIn is high in that cycle and earlyAbortCfg is 1.
- R6: When abortIn is high in the data cycle, the next cycle has abortTaken high for exactly one cycle and destWe low, and the block is idle in the cycle after that.
- R7: flush is high for one cycle, together with destWe, when the load completes without abort and either destIsPc was set or both baseIsPc and writeBack were set. It is never high after an aborted load.
- R8: A start strobe that arrives while busy is high is ignored. The running load keeps its captured fields and ends on schedule.
- R9: In the third cycle mergedFetch is high together with destWe while memReq is low. mergedFetch is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled only when idle) |
| sizeSel | input | 2 | Requested access size: 00 byte, 01 halfword, 10 word |
| userForm | input | 1 | Load-as-user form: forces unprivileged translation |
| writeBack | input | 1 | Base register write-back requested |
| baseIsPc | input | 1 | Base register is the program counter |
| destIsPc | input | 1 | Destination register is the program counter |
| modePriv | input | 1 | Current mode: 0 user, 1 privileged |
| earlyAbortCfg | input | 1 | Early-abort configuration |
| abortIn | input | 1 | Memory abort response in the data cycle |
| busy | output | 1 | A load is in progress |
| addrPhase | output | 1 | Address-calculation cycle |
| memReq | output | 1 | Data read request |
| xferSize | output | 2 | Transfer-size code for the data read |
| transPriv | output | 1 | Translation privilege for the data read |
| baseWe | output | 1 | Base register write-back enable |
| destWe | output | 1 | Destination register write enable |
| mergedFetch | output | 1 | Non-sequential prefetch request merged into cycle 3 |
| flush | output | 1 | Pipeline refill pulse after a program-counter write |
| abortTaken | output | 1 | One-cycle pulse after an aborted data read |

## Verification
The checker tests on every cycle the parts of the protocol that hold from one cycle to the next. These are: the address cycle always leads to the data cycle, a clean data cycle leads to the destination write with the merged fetch, and an abort leads to a single abortTaken pulse with no destination write. It also checks that the reserved size code never reaches the bus, that an early abort blocks write-back, and that flush only occurs with a destination write. Some results depend on the fields captured at start, and these only the directed scenarios can show. They are the mapping of size and privilege, the choice of when a program-counter write causes a flush, write-back surviving an abort when early-abort mode is off, and a second start being ignored in the middle of a load.

// File: rtl/ldSeqPkg.sv
package ldSeqPkg;
  localparam int SizeW = 2;
  localparam logic [SizeW-1:0] SizeByte = 2'b00;
  localparam logic [SizeW-1:0] SizeHalf = 2'b01;
  localparam logic [SizeW-1:0] SizeWord = 2'b10;
  localparam logic [SizeW-1:0] SizeRsvd = 2'b11;

  typedef enum logic [2:0] {
    StIdle  = 3'd0,
    StAddr  = 3'd1,
    StData  = 3'd2,
    StXfer  = 3'd3,
    StAbort = 3'd4
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic addrCycle;
    logic dataCycle;
    logic xferCycle;
    logic abortCycle;
  } seqStrobe_t;
endpackage

// File: rtl/ldSeqCtrl.sv
module ldSeqCtrl
  import ldSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       abortIn,
  output seqStrobe_t strobe,
  output logic       busy
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      StIdle:  if (start) stateD = StAddr;
      StAddr:  stateD = StData;
      StData:  stateD = abortIn ? StAbort : StXfer;
      StXfer:  stateD = StIdle;
      StAbort: stateD = StIdle;
      default: stateD = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= StIdle;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.capture    = (stateQ == StIdle) && start;
    strobe.addrCycle  = (stateQ == StAddr);
    strobe.dataCycle  = (stateQ == StData);
    strobe.xferCycle  = (stateQ == StXfer);
    strobe.abortCycle = (stateQ == StAbort);
    busy              = (stateQ != StIdle);
  end
endmodule

// File: rtl/ldSeqDatapath.sv
module ldSeqDatapath
  import ldSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [SizeW-1:0] sizeSel,
  input  logic             userForm,
  input  logic             writeBack,
  input  logic             baseIsPc,
  input  logic             destIsPc,
  input  logic             modePriv,
  input  logic             earlyAbortCfg,
  input  logic             abortIn,
  output logic             addrPhase,
  output logic             memReq,
  output logic [SizeW-1:0] xferSize,
  output logic             transPriv,
  output logic             baseWe,
  output logic             destWe,
  output logic             mergedFetch,
  output logic             flush,
  output logic             abortTaken
);
  logic [SizeW-1:0] sizeQ;
  logic userQ, wbQ, basePcQ, destPcQ, modeQ;
  logic [SizeW-1:0] sizeNorm;

  // The reserved code is widened to a word access before capture.
  assign sizeNorm = (sizeSel == SizeRsvd) ? SizeWord : sizeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ   <= SizeByte;
      userQ   <= 1'b0;
      wbQ     <= 1'b0;
      basePcQ <= 1'b0;
      destPcQ <= 1'b0;
      modeQ   <= 1'b0;
    end else if (strobe.capture) begin
      sizeQ   <= sizeNorm;
      userQ   <= userForm;
      wbQ     <= writeBack;
      basePcQ <= baseIsPc;
      destPcQ <= destIsPc;
      modeQ   <= modePriv;
    end
  end

  always_comb begin
    addrPhase   = strobe.addrCycle;
    memReq      = strobe.dataCycle;
    xferSize    = strobe.dataCycle ? sizeQ : SizeByte;
    transPriv   = strobe.dataCycle && !userQ && modeQ;
    baseWe      = strobe.dataCycle && wbQ && !(abortIn && earlyAbortCfg);
    destWe      = strobe.xferCycle;
    mergedFetch = strobe.xferCycle;
    flush       = strobe.xferCycle && (destPcQ || (basePcQ && wbQ));
    abortTaken  = strobe.abortCycle;
  end
endmodule

// File: rtl/loadSequencer.sv
module loadSequencer
  import ldSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] sizeSel,
  input  logic       userForm,
  input  logic       writeBack,
  input  logic       baseIsPc,
  input  logic       destIsPc,
  input  logic       modePriv,
  input  logic       earlyAbortCfg,
  input  logic       abortIn,
  output logic       busy,
  output logic       addrPhase,
  output logic       memReq,
  output logic [1:0] xferSize,
  output logic       transPriv,
  output logic       baseWe,
  output logic       destWe,
  output logic       mergedFetch,
  output logic       flush,
  output logic       abortTaken
);
  seqStrobe_t strobe;

  ldSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abortIn(abortIn),
    .strobe(strobe), .busy(busy)
  );

  ldSeqDatapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sizeSel(sizeSel), .userForm(userForm), .writeBack(writeBack),
    .baseIsPc(baseIsPc), .destIsPc(destIsPc), .modePriv(modePriv),
    .earlyAbortCfg(earlyAbortCfg), .abortIn(abortIn),
    .addrPhase(addrPhase), .memReq(memReq), .xferSize(xferSize),
    .transPriv(transPriv), .baseWe(baseWe), .destWe(destWe),
    .mergedFetch(mergedFetch), .flush(flush), .abortTaken(abortTaken)
  );
endmodule

// File: rtl/ldSeqChecker.sv
module ldSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       earlyAbortCfg,
  input logic       abortIn,
  input logic       busy,
  input logic       addrPhase,
  input logic       memReq,
  input logic [1:0] xferSize,
  input logic       baseWe,
  input logic       destWe,
  input logic       mergedFetch,
  input logic       flush,
  input logic       abortTaken
);
  assert_addr_then_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    addrPhase |=> memReq);
  assert_phases_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrPhase, memReq, destWe, abortTaken}));
  assert_phase_implies_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrPhase || memReq || destWe || abortTaken) |-> busy);
  assert_no_reserved_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> xferSize != 2'b11);
  assert_early_abort_blocks_wb_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && abortIn && earlyAbortCfg) |-> !baseWe);
  assert_wb_only_in_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |-> memReq);
  assert_abort_no_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && abortIn) |=> (abortTaken && !destWe));
  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    abortTaken |=> (!abortTaken && !busy));
  assert_flush_with_dest_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> destWe);
  assert_merged_fetch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !abortIn) |=> (destWe && mergedFetch && !memReq));
  assert_merged_only_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    mergedFetch |-> destWe);
endmodule

bind loadSequencer ldSeqChecker i_checker (
  .clk(clk), .rstN(rstN), .earlyAbortCfg(earlyAbortCfg), .abortIn(abortIn),
  .busy(busy), .addrPhase(addrPhase), .memReq(memReq), .xferSize(xferSize),
  .baseWe(baseWe), .destWe(destWe), .mergedFetch(mergedFetch),
  .flush(flush), .abortTaken(abortTaken)
);

// File: tb/test_loadSequencer.sv
module test_loadSequencer;
  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic [1:0] sizeSel;
  logic userForm, writeBack, baseIsPc, destIsPc, modePriv, earlyAbortCfg, abortIn;
  logic busy, addrPhase, memReq, transPriv, baseWe, destWe, mergedFetch, flush, abortTaken;
  logic [1:0] xferSize;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  loadSequencer i_loadSequencer (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .userForm(userForm), .writeBack(writeBack), .baseIsPc(baseIsPc),
    .destIsPc(destIsPc), .modePriv(modePriv), .earlyAbortCfg(earlyAbortCfg),
    .abortIn(abortIn), .busy(busy), .addrPhase(addrPhase), .memReq(memReq),
    .xferSize(xferSize), .transPriv(transPriv), .baseWe(baseWe),
    .destWe(destWe), .mergedFetch(mergedFetch), .flush(flush),
    .abortTaken(abortTaken)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int phaseVec();
    return {busy, addrPhase, memReq, baseWe, destWe, mergedFetch, flush, abortTaken};
  endfunction

  // Drives one load and checks every cycle of it. restartMid pulses start again in the address cycle.
  task automatic runLoad(input logic [1:0] sz, input logic uf, input logic wb,
                         input logic bpc, input logic dpc, input logic md,
                         input logic early, input logic abt, input logic restartMid);
    logic [1:0] expSize;
    expSize = (sz == 2'b11) ? 2'b10 : sz;
    @(negedge clk);
    start = 1'b1; sizeSel = sz; userForm = uf; writeBack = wb;
    baseIsPc = bpc; destIsPc = dpc; modePriv = md; earlyAbortCfg = early;
    @(negedge clk);
    // address cycle
    chk("R2", "addrPhase", int'(addrPhase), 1);
    chk("R2", "busy addr", int'(busy), 1);
    chk("R2", "memReq addr", int'(memReq), 0);
    if (restartMid) begin
      start = 1'b1; sizeSel = ~sz; userForm = ~uf; writeBack = ~wb;
      destIsPc = ~dpc; modePriv = ~md;
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0;
    sizeSel = sz; userForm = uf; writeBack = wb; destIsPc = dpc; modePriv = md;
    // data cycle
    abortIn = abt;
    #1;
    chk("R2", "memReq data", int'(memReq), 1);
    chk("R3", "xferSize", int'(xferSize), int'(expSize));
    chk("R4", "transPriv", int'(transPriv), int'(uf ? 1'b0 : md));
    chk("R5", "baseWe", int'(baseWe), int'(wb && !(abt && early)));
    chk("R9", "mergedFetch data", int'(mergedFetch), 0);
    @(negedge clk);
    abortIn = 1'b0;
    if (abt) begin
      chk("R6", "abortTaken", int'(abortTaken), 1);
      chk("R6", "destWe on abort", int'(destWe), 0);
      chk("R7", "flush on abort", int'(flush), 0);
      chk("R5", "baseWe after data", int'(baseWe), 0);
    end else begin
      chk("R2", "destWe", int'(destWe), 1);
      chk("R9", "mergedFetch", int'(mergedFetch), 1);
      chk("R9", "memReq xfer", int'(memReq), 0);
      chk("R7", "flush", int'(flush), int'(dpc || (bpc && wb)));
      chk("R6", "abortTaken clean", int'(abortTaken), 0);
    end
    chk("R2", "busy last", int'(busy), 1);
    @(negedge clk);
    chk(restartMid ? "R8" : "R2", "idle after load", phaseVec(), 0);
  endtask

  task automatic testReset();
    chk("R1", "reset outputs", phaseVec(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; sizeSel = 2'b00; userForm = 1'b0; writeBack = 1'b0;
    baseIsPc = 1'b0; destIsPc = 1'b0; modePriv = 1'b0; earlyAbortCfg = 1'b0; abortIn = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // sizes and privilege (R3, R4)
    runLoad(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runLoad(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runLoad(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runLoad(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // program-counter targets (R7)
    runLoad(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    runLoad(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    runLoad(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // aborts, late and early (R5, R6)
    runLoad(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    runLoad(2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    // start while busy (R8)
    runLoad(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    runLoad(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule